// File: doc/BRIEF.md
# Instruction Machine-Cycle Timing Sequencer

This block is the bus-cycle timing core of a small 8-bit processor. After a start strobe it takes a pre-decoded instruction-class code and steps through the ordered list of machine cycles that class needs. It counts the T-states of each machine cycle. For every clock it reports the type of the current machine cycle, the T-state index inside it, whether this clock opens a new machine cycle, and whether a two-byte transfer is on its high or low byte. A one-clock completion pulse marks the end of the instruction.

Conditional classes can shorten or lengthen their cycle list, and one of them also changes the length of a cycle. A single condition input decides which form runs. It is sampled once per instruction, at the clock edge that closes the last unconditional cycle. Addressing, data paths, opcode decoding and wait states lie outside this block. All outputs are registered.

Top module: `mcycle_sequencer`

## Requirements
- R1: After synchronous reset, and whenever no instruction is running, `busy`, `done`, `cyc_start` and `hi_half` are 0, `cyc_type` is 0 (idle) and `t_idx` is 0.
- R2: A `start` seen while idle is accepted. In the next clock the first machine cycle is a fetch (`cyc_type`=1) with `t_idx`=1 and `cyc_start`=1. A `start` raised while `busy` is 1 is ignored and does not change the running sequence.
- R3: Inside each machine cycle `t_idx` runs 1, 2, … up to that cycle's length, one step per clock. `cyc_start` is 1 exactly on clocks where `t_idx`=1.
- R4: Cycle type codes are: fetch 1, operand read 2, memory read 3, memory write 4, stack read 5, stack write 6, port read 7, port write 8, internal 9. Single-access classes run the following cycles. Class 0: F4. Class 1: F4 then operand 3. Class 2: F4 then memory read 3. Class 3: F4 then memory write 3. Class 14: F4, operand 3, port read 4. Class 15: F4, operand 3, port write 4. Class 16: F4, memory read 4, memory write 3.
- R5: Class 4 (prefixed register op) runs F4, F4. Class 5 (indexed read) runs F4, F4, operand 3, internal 5, memory read 3. Class 6 (indexed write) runs the same list with a final memory write 3.
- R6: Class 7 (conditional relative jump) runs F4 then operand 3, and adds internal 5 only when the condition is 1. Class 8 (decrement-and-branch, condition meaning counter not zero) does the same with a fetch of 5. For both, the condition is sampled at the edge ending the last T-state of the operand read.
- R7: Class 9 (conditional call) runs F4 then operand-low 3. With the condition at 1 it continues with operand-high 4, stack write high 3 and stack write low 3. With the condition at 0 it ends after operand-high 3. The condition is sampled at the edge ending operand-low.
- R8: Class 10 (conditional return) runs F5. Only with the condition at 1 does it add stack read low 3, then stack read high 3. The condition is sampled at the edge ending the fetch.
- R9: `hi_half` is 1 on high-byte transfers. Class 11 (push) runs F5, stack write high 3, stack write low 3. Class 12 (pop) runs F4, stack read low 3, stack read high 3. Class 13 (exchange with stack top) runs F4, stack read low 3, stack read high 4, stack write high 3, stack write low 5.
- R10: `done` is 1 for exactly one clock, the clock after the final T-state. In that clock `busy` is 0 and a new `start` is accepted.
- R11: Any class code not listed above (17 to 31) runs a single 4-T fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| iclass | input | 5 | Pre-decoded instruction-class code, sampled with `start` |
| cond | input | 1 | Condition result for conditional classes |
| cyc_type | output | 4 | Current machine-cycle type code (0 when idle) |
| t_idx | output | 3 | T-state index within the current cycle (0 when idle) |
| cyc_start | output | 1 | High on the first T-state of each machine cycle |
| hi_half | output | 1 | High when the current transfer is the high byte |
| busy | output | 1 | An instruction is running |
| done | output | 1 | One-clock pulse after the final T-state |

## Verification
A wrong step index or a stale taken flag shows up as a wrong `cyc_type` or `hi_half` on the very clock where the next machine cycle opens. A wrong T-state count shows up in `t_idx` or `cyc_start` within one clock. A wrongly captured condition changes the remaining list, so it shows as early or late `done` or as an extra internal cycle right after the sampled edge. The bench drives the condition to the opposite value everywhere except the sampling T-state, so a sample taken at the wrong edge flips the branch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int CLS_W  = 5;
  localparam int TYPE_W = 4;
  localparam int LEN_W  = 3;

  typedef enum logic [TYPE_W-1:0] {
    CY_IDLE  = 4'd0,
    CY_FETCH = 4'd1,
    CY_OPND  = 4'd2,
    CY_MRD   = 4'd3,
    CY_MWR   = 4'd4,
    CY_SRD   = 4'd5,
    CY_SWR   = 4'd6,
    CY_PRD   = 4'd7,
    CY_PWR   = 4'd8,
    CY_INTL  = 4'd9
  } cyc_e;

  localparam logic [CLS_W-1:0] K_PLAIN    = 5'd0;
  localparam logic [CLS_W-1:0] K_IMM      = 5'd1;
  localparam logic [CLS_W-1:0] K_LOAD     = 5'd2;
  localparam logic [CLS_W-1:0] K_STORE    = 5'd3;
  localparam logic [CLS_W-1:0] K_PFX      = 5'd4;
  localparam logic [CLS_W-1:0] K_IXLOAD   = 5'd5;
  localparam logic [CLS_W-1:0] K_IXSTORE  = 5'd6;
  localparam logic [CLS_W-1:0] K_RELJ     = 5'd7;
  localparam logic [CLS_W-1:0] K_DECBR    = 5'd8;
  localparam logic [CLS_W-1:0] K_CALLC    = 5'd9;
  localparam logic [CLS_W-1:0] K_RETC     = 5'd10;
  localparam logic [CLS_W-1:0] K_PUSH     = 5'd11;
  localparam logic [CLS_W-1:0] K_POP      = 5'd12;
  localparam logic [CLS_W-1:0] K_XSTK     = 5'd13;
  localparam logic [CLS_W-1:0] K_PIN      = 5'd14;
  localparam logic [CLS_W-1:0] K_POUT     = 5'd15;
  localparam logic [CLS_W-1:0] K_RMW      = 5'd16;

  typedef struct packed {
    logic             valid;
    cyc_e             kind;
    logic [LEN_W-1:0] len;
    logic             hi;
    logic             branch;
  } step_t;

endpackage

// File: rtl/mcs_step_table.sv
module mcs_step_table
  import mcs_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [IDX_W-1:0] idx,
  input  logic             taken,
  output step_t            step
);

  function automatic step_t mk(input cyc_e k, input int unsigned l,
                               input logic h, input logic b);
    step_t s;
    s.valid  = 1'b1;
    s.kind   = k;
    s.len    = LEN_W'(l);
    s.hi     = h;
    s.branch = b;
    return s;
  endfunction

  localparam step_t NONE = '0;

  always_comb begin
    step = NONE;
    if (idx == '0) begin
      // first cycle is always a fetch; its length depends on the class
      unique case (cls)
        K_DECBR, K_PUSH: step = mk(CY_FETCH, 5, 1'b0, 1'b0);
        K_RETC:          step = mk(CY_FETCH, 5, 1'b0, 1'b1);
        default:         step = mk(CY_FETCH, 4, 1'b0, 1'b0);
      endcase
    end else begin
      unique case (cls)
        K_IMM:   if (idx == 1) step = mk(CY_OPND, 3, 1'b0, 1'b0);
        K_LOAD:  if (idx == 1) step = mk(CY_MRD, 3, 1'b0, 1'b0);
        K_STORE: if (idx == 1) step = mk(CY_MWR, 3, 1'b0, 1'b0);
        K_PFX:   if (idx == 1) step = mk(CY_FETCH, 4, 1'b0, 1'b0);
        K_IXLOAD, K_IXSTORE: begin
          case (idx)
            3'd1: step = mk(CY_FETCH, 4, 1'b0, 1'b0);
            3'd2: step = mk(CY_OPND, 3, 1'b0, 1'b0);
            3'd3: step = mk(CY_INTL, 5, 1'b0, 1'b0);
            3'd4: step = mk((cls == K_IXLOAD) ? CY_MRD : CY_MWR, 3, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_RELJ, K_DECBR: begin
          case (idx)
            3'd1: step = mk(CY_OPND, 3, 1'b0, 1'b1);
            3'd2: if (taken) step = mk(CY_INTL, 5, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_CALLC: begin
          case (idx)
            3'd1: step = mk(CY_OPND, 3, 1'b0, 1'b1);
            3'd2: step = mk(CY_OPND, taken ? 4 : 3, 1'b1, 1'b0);
            3'd3: if (taken) step = mk(CY_SWR, 3, 1'b1, 1'b0);
            3'd4: if (taken) step = mk(CY_SWR, 3, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_RETC: begin
          case (idx)
            3'd1: if (taken) step = mk(CY_SRD, 3, 1'b0, 1'b0);
            3'd2: if (taken) step = mk(CY_SRD, 3, 1'b1, 1'b0);
            default: step = NONE;
          endcase
        end
        K_PUSH: begin
          case (idx)
            3'd1: step = mk(CY_SWR, 3, 1'b1, 1'b0);
            3'd2: step = mk(CY_SWR, 3, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_POP: begin
          case (idx)
            3'd1: step = mk(CY_SRD, 3, 1'b0, 1'b0);
            3'd2: step = mk(CY_SRD, 3, 1'b1, 1'b0);
            default: step = NONE;
          endcase
        end
        K_XSTK: begin
          case (idx)
            3'd1: step = mk(CY_SRD, 3, 1'b0, 1'b0);
            3'd2: step = mk(CY_SRD, 4, 1'b1, 1'b0);
            3'd3: step = mk(CY_SWR, 3, 1'b1, 1'b0);
            3'd4: step = mk(CY_SWR, 5, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_PIN, K_POUT: begin
          case (idx)
            3'd1: step = mk(CY_OPND, 3, 1'b0, 1'b0);
            3'd2: step = mk((cls == K_PIN) ? CY_PRD : CY_PWR, 4, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        K_RMW: begin
          case (idx)
            3'd1: step = mk(CY_MRD, 4, 1'b0, 1'b0);
            3'd2: step = mk(CY_MWR, 3, 1'b0, 1'b0);
            default: step = NONE;
          endcase
        end
        default: step = NONE; // plain and unknown classes: fetch only
      endcase
    end
  end

  // a valid step never has a length below 3 or above 5
  always_comb begin
    if (step.valid) begin
      a_len_window_r4: assert (step.len >= 3 && step.len <= 5)
        else $error("step length out of window");
    end
  end

endmodule

// File: rtl/mcs_tcount.sv
module mcs_tcount #(
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           clear,
  input  logic [T_W-1:0] len,
  output logic [T_W-1:0] t,
  output logic           last
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      t <= '0;
    end else if (load) begin
      t <= T_W'(1);
    end else if (t != '0) begin
      t <= t + T_W'(1);
    end
  end

  assign last = (t != '0) && (t == len);

  p_t_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (t != '0) |-> (t <= len));

  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (t != '0 && !last && !load && !clear) |=> (t == $past(t) + T_W'(1)));

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcs_pkg::*;
#(
  parameter int MAX_STEPS = 5,
  parameter int T_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [4:0]       iclass,
  input  logic             cond,
  output logic [3:0]       cyc_type,
  output logic [T_W-1:0]   t_idx,
  output logic             cyc_start,
  output logic             hi_half,
  output logic             busy,
  output logic             done
);

  localparam int IDX_W = $clog2(MAX_STEPS + 1);

  logic [CLS_W-1:0] cls_q;
  logic [IDX_W-1:0] idx_q;
  logic             taken_q;
  step_t            cur_q;
  step_t            first_step;
  step_t            next_step;
  logic             nxt_taken;
  logic             last_t;
  logic             go;
  logic             adv;
  logic             fin;

  assign nxt_taken = cur_q.branch ? cond : taken_q;

  mcs_step_table #(.IDX_W(IDX_W)) u_tab_first (
    .cls   (iclass),
    .idx   ('0),
    .taken (1'b0),
    .step  (first_step)
  );

  mcs_step_table #(.IDX_W(IDX_W)) u_tab_next (
    .cls   (cls_q),
    .idx   (idx_q + IDX_W'(1)),
    .taken (nxt_taken),
    .step  (next_step)
  );

  assign go  = !busy && start;
  assign adv = busy && last_t && next_step.valid;
  assign fin = busy && last_t && !next_step.valid;

  mcs_tcount #(.T_W(T_W)) u_tcnt (
    .clk   (clk),
    .rst   (rst),
    .load  (go || adv),
    .clear (fin),
    .len   (T_W'(cur_q.len)),
    .t     (t_idx),
    .last  (last_t)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cyc_start <= 1'b0;
      cls_q     <= '0;
      idx_q     <= '0;
      taken_q   <= 1'b0;
      cur_q     <= '0;
    end else begin
      cyc_start <= 1'b0;
      done      <= 1'b0;
      if (go) begin
        busy      <= 1'b1;
        cls_q     <= iclass;
        idx_q     <= '0;
        taken_q   <= 1'b0;
        cur_q     <= first_step;
        cyc_start <= 1'b1;
      end else if (adv) begin
        idx_q     <= idx_q + IDX_W'(1);
        taken_q   <= nxt_taken;
        cur_q     <= next_step;
        cyc_start <= 1'b1;
      end else if (fin) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        cur_q <= '0;
      end
    end
  end

  assign cyc_type = cur_q.kind;
  assign hi_half  = cur_q.hi;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cyc_type == CY_IDLE && t_idx == '0 && !cyc_start && !hi_half));

  p_first_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && cyc_type == CY_FETCH && cyc_start && t_idx == T_W'(1)));

  p_class_held_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cls_q));

  p_open_at_one_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> (t_idx == T_W'(1)));

  p_fetch_len_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == CY_FETCH && last_t) |-> (t_idx == T_W'(4) || t_idx == T_W'(5)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/mcycle_sequencer_test.sv
module mcycle_sequencer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [4:0] iclass;
  logic       cond;
  logic [3:0] cyc_type;
  logic [2:0] t_idx;
  logic       cyc_start;
  logic       hi_half;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mcycle_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .iclass(iclass), .cond(cond),
    .cyc_type(cyc_type), .t_idx(t_idx), .cyc_start(cyc_start),
    .hi_half(hi_half), .busy(busy), .done(done)
  );

  typedef struct {
    int ty;
    int t;
    bit cs;
    bit hi;
    bit samp;
  } ent_t;

  ent_t exp_q[$];

  function automatic void add(int ty, int len, bit hi, bit samp);
    for (int i = 1; i <= len; i++) begin
      ent_t e;
      e.ty = ty; e.t = i; e.cs = (i == 1); e.hi = hi;
      e.samp = samp && (i == len);
      exp_q.push_back(e);
    end
  endfunction

  // reference lists, built from the requirement text
  function automatic void build(int cls, bit tk);
    exp_q.delete();
    case (cls)
      0:  add(1, 4, 0, 0);
      1:  begin add(1, 4, 0, 0); add(2, 3, 0, 0); end
      2:  begin add(1, 4, 0, 0); add(3, 3, 0, 0); end
      3:  begin add(1, 4, 0, 0); add(4, 3, 0, 0); end
      4:  begin add(1, 4, 0, 0); add(1, 4, 0, 0); end
      5, 6: begin
        add(1, 4, 0, 0); add(1, 4, 0, 0); add(2, 3, 0, 0); add(9, 5, 0, 0);
        add(cls == 5 ? 3 : 4, 3, 0, 0);
      end
      7, 8: begin
        add(1, cls == 8 ? 5 : 4, 0, 0); add(2, 3, 0, 1);
        if (tk) add(9, 5, 0, 0);
      end
      9: begin
        add(1, 4, 0, 0); add(2, 3, 0, 1);
        if (tk) begin add(2, 4, 1, 0); add(6, 3, 1, 0); add(6, 3, 0, 0); end
        else add(2, 3, 1, 0);
      end
      10: begin
        add(1, 5, 0, 1);
        if (tk) begin add(5, 3, 0, 0); add(5, 3, 1, 0); end
      end
      11: begin add(1, 5, 0, 0); add(6, 3, 1, 0); add(6, 3, 0, 0); end
      12: begin add(1, 4, 0, 0); add(5, 3, 0, 0); add(5, 3, 1, 0); end
      13: begin
        add(1, 4, 0, 0); add(5, 3, 0, 0); add(5, 4, 1, 0);
        add(6, 3, 1, 0); add(6, 5, 0, 0);
      end
      14: begin add(1, 4, 0, 0); add(2, 3, 0, 0); add(7, 4, 0, 0); end
      15: begin add(1, 4, 0, 0); add(2, 3, 0, 0); add(8, 4, 0, 0); end
      16: begin add(1, 4, 0, 0); add(3, 4, 0, 0); add(4, 3, 0, 0); end
      default: add(1, 4, 0, 0);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // called at a falling edge; returns at the falling edge of the done clock
  task automatic run(int cls, bit tk, bit wiggle, bit poke, string tag);
    build(cls, tk);
    start  = 1'b1;
    iclass = 5'(cls);
    cond   = wiggle ? !tk : tk;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      check(cyc_type == exp_q[i].ty && busy && !done, tag, "cycle type",
            int'(cyc_type), exp_q[i].ty);
      check(hi_half == exp_q[i].hi, tag, "byte half", int'(hi_half), int'(exp_q[i].hi));
      check(t_idx == exp_q[i].t && cyc_start == exp_q[i].cs, "R3", "t index",
            int'(t_idx), exp_q[i].t);
      if (wiggle) cond = exp_q[i].samp ? tk : !tk;
      if (poke && i == 2) begin
        // R2: start while busy must be ignored
        start  = 1'b1;
        iclass = 5'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy && cyc_type == 0 && t_idx == 0, "R10", "done/idle",
          int'(done), 1);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(!done && !busy && cyc_type == 0 && t_idx == 0 && !cyc_start && !hi_half,
          "R1", "idle outputs", int'(busy), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; iclass = '0; cond = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && cyc_type == 0 && t_idx == 0 && !cyc_start, "R1",
          "reset state", int'(busy), 0);
    idle_check();

    run(0,  0, 0, 0, "R4");
    run(1,  0, 0, 0, "R4");
    run(2,  0, 0, 0, "R4");
    run(3,  0, 0, 0, "R4");
    idle_check();
    run(14, 0, 0, 0, "R4");
    run(15, 0, 0, 0, "R4");
    run(16, 0, 0, 0, "R4");
    run(4,  0, 0, 0, "R5");
    run(5,  0, 0, 0, "R5");
    run(6,  0, 0, 0, "R5");
    run(7,  1, 0, 0, "R6");
    run(7,  0, 0, 0, "R6");
    run(7,  1, 1, 0, "R6");
    run(7,  0, 1, 0, "R6");
    run(8,  1, 1, 0, "R6");
    run(8,  0, 0, 0, "R6");
    run(9,  1, 1, 0, "R7");
    run(9,  0, 1, 0, "R7");
    run(10, 1, 1, 0, "R8");
    run(10, 0, 1, 0, "R8");
    idle_check();
    run(11, 0, 0, 0, "R9");
    run(12, 0, 0, 0, "R9");
    run(13, 0, 0, 0, "R9");
    run(17, 0, 0, 0, "R11");
    run(31, 1, 0, 0, "R11");
    run(5,  0, 0, 1, "R2");
    run(13, 0, 0, 1, "R2");
    idle_check();
    idle_check();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule